// File: doc/BRIEF.md
# Clock-Synchronous Reset Sequencer

This block turns a single active-low system reset request into the ordered set of internal reset controls that a small processor core needs. The request pin is sampled only on rising clock edges and has no noise filter. When it has been seen low on a fixed number of consecutive edges, the block puts the core into reset and flags that initialization is complete. Once the pin has been high again for a second fixed number of edges, the block releases the core reset. In that same cycle it sends a one-cycle pipeline flush and a one-cycle fetch-start request whose address is the restart vector, zero by default.

The same request pin also brings the core out of power-save. On the first edge that samples the pin low while power-save is active, the block sends a one-cycle exit pulse. A low run that is too short to complete initialization leaves the core reset state as it was. A low sample during the release countdown sends the sequence back to counting low edges from the beginning.

The block's own registers are cleared by a separate synchronous active-low power-on reset. After that reset the core is held in reset until a full sequence has completed.

Top module: `reset_sequencer`

## Requirements
- R1: While and right after the power-on reset, core_reset is 1 and init_done, pipe_flush, fetch_start and psave_exit are all 0.
- R2: When rst_in_n is sampled low on LOW_EDGES (default 5) consecutive edges, init_done and core_reset are both 1 after the last of those edges. After only LOW_EDGES-1 such edges, init_done is still 0.
- R3: If rst_in_n returns high before LOW_EDGES low samples have been taken, init_done stays 0, no fetch_start follows, and core_reset keeps the value it had before the low run.
- R4: Once initialization is complete, the HIGH_EDGES-th (default 4) consecutive edge that samples rst_in_n high makes fetch_start and pipe_flush 1 for exactly one cycle. At that edge core_reset drops to 0 and init_done drops to 0.
- R5: fetch_addr equals START_ADDR (default 0) in every cycle in which fetch_start is 1.
- R6: A low sample of rst_in_n during the release countdown cancels the countdown. No fetch_start is issued, init_done goes to 0, core_reset stays 1, and LOW_EDGES fresh low samples are needed again.
- R7: psave_exit is 1 for one cycle after an edge that samples rst_in_n low when the previous sample was high (or the previous cycle was in power-on reset) and sleep_i is 1 at that edge. It is 0 otherwise.
- R8: While rst_in_n is held low past LOW_EDGES edges, init_done and core_reset stay 1 and no fetch_start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| por_n | input | 1 | Synchronous active-low reset of the sequencer itself |
| rst_in_n | input | 1 | Active-low system reset request, unfiltered |
| sleep_i | input | 1 | 1 while the core is in power-save |
| core_reset | output | 1 | Active-high internal reset to the core |
| init_done | output | 1 | 1 from initialization completion until the start edge |
| pipe_flush | output | 1 | One-cycle pipeline flush pulse at start |
| fetch_start | output | 1 | One-cycle start-fetch request |
| fetch_addr | output | ADDR_W | Address of the first fetch |
| psave_exit | output | 1 | One-cycle power-save exit pulse |

## Verification
The assertions assume that rst_in_n and sleep_i are stable around each rising edge. They also assume that por_n is applied first, so the $past values seen right after it are defined. The bench changes every input only at the falling edge and holds por_n low for several cycles before any reset request. The random phase draws low and high runs of length one to eight. These lengths land on both sides of both edge counts and cut into the release countdown at every position, and sleep_i is drawn fresh on every cycle.

// File: rtl/rstseq_pkg.sv
// Shared types for the reset sequencer.
package rstseq_pkg;
    // Sequence phase of the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,  // no sequence in progress
        PH_LOWCNT = 2'd1,  // counting low samples
        PH_HELD   = 2'd2,  // initialization complete, request still low
        PH_RELCNT = 2'd3   // counting high samples after release
    } phase_e;
endpackage

// File: rtl/rstseq_edge_counter.sv
// Saturating edge counter. It counts the edges on which inc_i is set and
// signals the edge that brings the count to LIMIT.
// Assumes LIMIT >= 2. clear_i wins over inc_i.
module rstseq_edge_counter #(
    parameter int LIMIT = 5
) (
    input  logic clk,
    input  logic por_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    // Flag the edge on which the LIMIT-th counted event arrives.
    assign hit_o = inc_i && !clear_i && (cnt == LAST);

    // Count events, holding at LAST.
    always_ff @(posedge clk) begin
        if (!por_n)                      cnt <= '0;
        else if (clear_i)                cnt <= '0;
        else if (inc_i && cnt != LAST)   cnt <= cnt + 1'b1;
    end

    assert_count_bounded_R2: assert property (@(posedge clk) disable iff (!por_n)
        cnt <= LAST);
endmodule

// File: rtl/rstseq_wake_detect.sv
// Power-save exit detector. It pulses for one cycle on the first edge that
// samples the reset request low while power-save is active.
// Assumes that the previous sample counts as high right after power-on reset.
module rstseq_wake_detect (
    input  logic clk,
    input  logic por_n,
    input  logic rst_in_n,
    input  logic sleep_i,
    output logic psave_exit_o
);
    logic prev_n;

    // Remember the previous sample and form the exit pulse.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            prev_n       <= 1'b1;
            psave_exit_o <= 1'b0;
        end else begin
            prev_n       <= rst_in_n;
            psave_exit_o <= !rst_in_n && prev_n && sleep_i;
        end
    end

    assert_wake_cause_R7: assert property (@(posedge clk) disable iff (!por_n)
        psave_exit_o |-> ($past(sleep_i) && !$past(rst_in_n)));
    assert_wake_single_R7: assert property (@(posedge clk) disable iff (!por_n)
        psave_exit_o |=> !psave_exit_o);
endmodule

// File: rtl/reset_sequencer.sv
// Clock-synchronous reset sequencer. It counts low samples of the reset
// request up to LOW_EDGES, then holds the core in reset with init_done set.
// It then counts HIGH_EDGES high samples and releases the core with a
// flush and a fetch start at START_ADDR.
// Assumes rst_in_n is synchronous to clk, LOW_EDGES >= 2 and HIGH_EDGES >= 2.
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int              LOW_EDGES  = 5,
    parameter int              HIGH_EDGES = 4,
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_in_n,
    input  logic              sleep_i,
    output logic              core_reset,
    output logic              init_done,
    output logic              pipe_flush,
    output logic              fetch_start,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              psave_exit
);
    phase_e phase, phase_nx;
    logic   low_inc, low_hit, high_inc, high_hit;
    logic   start_nx;

    // Low samples count while no completed initialization is held.
    assign low_inc  = !rst_in_n && (phase != PH_HELD);
    // High samples count only after initialization is complete.
    assign high_inc = rst_in_n && (phase == PH_HELD || phase == PH_RELCNT);

    rstseq_edge_counter #(.LIMIT(LOW_EDGES)) u_low_cnt (
        .clk(clk), .por_n(por_n), .clear_i(rst_in_n),
        .inc_i(low_inc), .hit_o(low_hit));

    rstseq_edge_counter #(.LIMIT(HIGH_EDGES)) u_high_cnt (
        .clk(clk), .por_n(por_n), .clear_i(!rst_in_n),
        .inc_i(high_inc), .hit_o(high_hit));

    rstseq_wake_detect u_wake (
        .clk(clk), .por_n(por_n), .rst_in_n(rst_in_n),
        .sleep_i(sleep_i), .psave_exit_o(psave_exit));

    // Choose the next phase from the current phase and the sampled request.
    always_comb begin
        phase_nx = phase;
        start_nx = 1'b0;
        unique case (phase)
            PH_IDLE:   if (!rst_in_n) phase_nx = PH_LOWCNT;
            PH_LOWCNT: if (rst_in_n)  phase_nx = PH_IDLE;
                       else if (low_hit) phase_nx = PH_HELD;
            PH_HELD:   if (rst_in_n)  phase_nx = PH_RELCNT;
            PH_RELCNT: if (!rst_in_n) phase_nx = PH_LOWCNT;
                       else if (high_hit) begin
                           phase_nx = PH_IDLE;
                           start_nx = 1'b1;
                       end
            default:   phase_nx = PH_IDLE;
        endcase
    end

    // Register the phase and the reset and start outputs.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            phase       <= PH_IDLE;
            core_reset  <= 1'b1;
            fetch_start <= 1'b0;
            pipe_flush  <= 1'b0;
        end else begin
            phase       <= phase_nx;
            fetch_start <= start_nx;
            pipe_flush  <= start_nx;
            if (phase == PH_LOWCNT && low_hit) core_reset <= 1'b1;
            else if (start_nx)                 core_reset <= 1'b0;
        end
    end

    assign init_done  = (phase == PH_HELD) || (phase == PH_RELCNT);
    assign fetch_addr = START_ADDR;

    assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!por_n)
        fetch_start |=> !fetch_start);
    assert_start_after_high_R4: assert property (@(posedge clk) disable iff (!por_n)
        fetch_start |-> $past(rst_in_n));
    assert_release_on_start_R4: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_reset) |-> (fetch_start && pipe_flush));
    assert_init_needs_low_R2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(init_done) |-> (!$past(rst_in_n) && core_reset));
    assert_no_start_on_low_R6: assert property (@(posedge clk) disable iff (!por_n)
        !rst_in_n |=> !fetch_start);
    assert_held_keeps_reset_R8: assert property (@(posedge clk) disable iff (!por_n)
        init_done |-> core_reset);
endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb_top;
    localparam int LE = 5;
    localparam int HE = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          rst_in_n = 1'b1;
    logic          sleep_i = 1'b0;
    logic          core_reset, init_done, pipe_flush, fetch_start, psave_exit;
    logic [AW-1:0] fetch_addr;

    int total = 0;
    int fails = 0;

    // Reference model state.
    int m_phase;   // 0 idle, 1 low count, 2 held, 3 release count
    int m_lo, m_hi;
    bit m_core, m_prev, m_fetch, m_wake;

    always #5 clk = ~clk;

    reset_sequencer #(.LOW_EDGES(LE), .HIGH_EDGES(HE), .ADDR_W(AW)) dut_i (
        .clk(clk), .por_n(por_n), .rst_in_n(rst_in_n), .sleep_i(sleep_i),
        .core_reset(core_reset), .init_done(init_done), .pipe_flush(pipe_flush),
        .fetch_start(fetch_start), .fetch_addr(fetch_addr), .psave_exit(psave_exit));

    function automatic bit model_init();
        return (m_phase == 2) || (m_phase == 3);
    endfunction

    task automatic model_por();
        m_phase = 0; m_lo = 0; m_hi = 0;
        m_core = 1'b1; m_prev = 1'b1; m_fetch = 1'b0; m_wake = 1'b0;
    endtask

    task automatic model_step(input bit rn, input bit sl);
        m_wake  = !rn && m_prev && sl;
        m_prev  = rn;
        m_fetch = 1'b0;
        case (m_phase)
            0: if (!rn) begin m_lo = 1; m_phase = 1; end
            1: if (rn) m_phase = 0;
               else if (m_lo == LE - 1) begin m_phase = 2; m_core = 1'b1; end
               else m_lo++;
            2: if (rn) begin m_hi = 1; m_phase = 3; end
            3: if (!rn) begin m_lo = 1; m_phase = 1; end
               else if (m_hi == HE - 1) begin m_fetch = 1'b1; m_core = 1'b0; m_phase = 0; end
               else m_hi++;
            default: m_phase = 0;
        endcase
    endtask

    task automatic check(input string tag, input string what, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "core_reset", AW'(core_reset), AW'(m_core));
        check(tag, "init_done", AW'(init_done), AW'(model_init()));
        check(tag, "fetch_start", AW'(fetch_start), AW'(m_fetch));
        check(tag, "pipe_flush", AW'(pipe_flush), AW'(m_fetch));
        check(tag, "psave_exit", AW'(psave_exit), AW'(m_wake));
        if (m_fetch) check("R5", "fetch_addr", fetch_addr, '0);
    endtask

    // Drive at the falling edge, let the rising edge act, then compare.
    task automatic step(input bit rn, input bit sl, input string tag);
        @(negedge clk);
        rst_in_n = rn;
        sleep_i  = sl;
        @(posedge clk);
        #1;
        model_step(rn, sl);
        check_all(tag);
    endtask

    task automatic run(input bit rn, input int n, input bit sl, input string tag);
        for (int i = 0; i < n; i++) step(rn, sl, tag);
    endtask

    initial begin
        #1_000_000;
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_por();
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        @(negedge clk);
        por_n = 1'b1;

        // R2: four lows do not complete; the fifth does.
        run(1'b0, LE - 1, 1'b0, "R2");
        check("R2", "init_before_limit", AW'(init_done), '0);
        step(1'b0, 1'b0, "R2");
        check("R2", "init_at_limit", AW'(init_done), AW'(1));
        // R8: keep holding low.
        run(1'b0, 6, 1'b0, "R8");
        // R4/R5: release and count four highs.
        run(1'b1, HE, 1'b0, "R4");
        check("R4", "core_released", AW'(core_reset), '0);
        step(1'b1, 1'b0, "R4");
        check("R4", "pulse_one_cycle", AW'(fetch_start), '0);
        // R3: short low run while running, with power-save active (R7).
        step(1'b0, 1'b1, "R7");
        check("R7", "wake_pulse", AW'(psave_exit), AW'(1));
        run(1'b0, 2, 1'b1, "R3");
        check("R7", "wake_once", AW'(psave_exit), '0);
        run(1'b1, 8, 1'b0, "R3");
        check("R3", "core_still_running", AW'(core_reset), '0);
        // R7: low edge without power-save gives no pulse.
        step(1'b0, 1'b0, "R7");
        check("R7", "no_wake_when_awake", AW'(psave_exit), '0);
        run(1'b0, LE - 1, 1'b0, "R2");
        // R6: release interrupted at the third high edge.
        run(1'b1, HE - 1, 1'b0, "R6");
        step(1'b0, 1'b0, "R6");
        check("R6", "init_cleared", AW'(init_done), '0);
        run(1'b1, HE + 2, 1'b0, "R6");
        check("R6", "still_in_reset", AW'(core_reset), AW'(1));
        run(1'b0, LE, 1'b0, "R6");
        run(1'b1, HE + 1, 1'b0, "R4");

        // Random runs of low and high.
        for (int r = 0; r < 600; r++) begin
            bit lvl = r[0];
            int len = 1 + int'($urandom % 8);
            for (int k = 0; k < len; k++) step(lvl, bit'($urandom % 2), "RND");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule